// File: doc/BRIEF.md
# Transmit FIFO Command Decoder with Underrun Purge

This block sits on the read side of a 36-bit transmit FIFO that a transfer scheduler fills for a host-side USB packet engine. When the scheduler raises a run request and the block is idle, it reads one start-of-packet command entry. It splits that entry into device address, endpoint, speed, transfer type, data toggle and PID, and holds these fields for the packet engine. It then passes the following data words on, one per cycle. An end-of-packet entry closes the packet, and the block reports a result code back to the scheduler.

If the FIFO runs dry in the middle of a packet, the block raises a one-cycle request to send a deliberately corrupted packet. It then waits out a bus-timeout interval and enters a purge mode. Purge throws away any data the scheduler back-filled for the failed packet. It stops when the FIFO is empty or when the entry at the head of the FIFO is a start-of-packet command. That command is left in the FIFO, so the next transaction begins on a clean command boundary.

Top module: `txfifo_cmd_decoder`

## Requirements
- R1: Each FIFO entry is 36 bits. Bits 35:32 are the tag: 0x0 is a start-of-packet command, 0x1 is a data word and 0xF is end-of-packet. On data entries, bits 31:0 are the payload.
- R2: A command is accepted from the FIFO head only if its tag is 0x0. Its fields are decoded as follows: endpoint from bits 26:23 (the low 4 bits of field 29:23), address from 22:16, speed from 9:8, type from 7:6, toggle from 5:4 and PID from 3:0. The decoded outputs hold these values until the next accepted command.
- R3: The block never reads the FIFO while idle. A fetch starts only on the clock edge at which `run_pkt_i` is high while the block is idle.
- R4: While draining, each tag 0x1 entry is popped. Its payload appears on `data_o`, with `data_valid_o` high, for the one cycle after the pop.
- R5: A tag 0xF entry while draining is popped and ends the packet with result code 2'b00 (ok).
- R6: If the fetched head entry has a nonzero tag, it is popped and the block returns to idle with result code 2'b10 (error). The decoded command outputs are left unchanged.
- R7: If the FIFO is empty while draining, `bad_pkt_o` pulses for one cycle. No entry is read for TIMEOUT_CYC cycles after that pulse, and the first purge read may happen exactly TIMEOUT_CYC cycles after it.
- R8: Purge pops and discards every entry whose tag is not 0x0. It stops when the FIFO is empty or when the head tag is 0x0, leaves that entry unread, and reports result code 2'b01 (underrun).
- R9: Each fetch produces exactly one `done_o` pulse, one cycle wide.
- R10: If a tag 0x0 entry appears while draining (no end-of-packet was seen), the packet ends with result code 2'b10 and that entry stays in the FIFO.
- R11: The FIFO is never read while `fifo_empty_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | FIFO has no entry |
| fifo_data_i | input | 36 | Head entry of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Pop the head entry on this edge |
| run_pkt_i | input | 1 | Scheduler request to run one packet |
| cmd_active_o | output | 1 | High while packet data is being drained |
| cmd_addr_o | output | 7 | Decoded device address |
| cmd_ep_o | output | 4 | Decoded endpoint number |
| cmd_speed_o | output | 2 | Decoded endpoint speed |
| cmd_type_o | output | 2 | Decoded endpoint type |
| cmd_toggle_o | output | 2 | Decoded data toggle |
| cmd_pid_o | output | 4 | Decoded PID |
| data_valid_o | output | 1 | Data word valid on data_o |
| data_o | output | 32 | Packet data word |
| bad_pkt_o | output | 1 | Request to send a corrupted packet after an underrun |
| done_o | output | 1 | Completion pulse |
| done_code_o | output | 2 | Result code: 00 ok, 01 underrun, 10 error |

## Verification
Some rules hold on every cycle, and the embedded properties check them continuously: no read while idle, while waiting out the timeout, or while the FIFO is empty; a start-of-packet entry at the head is never read during purge; completion and bad-packet strobes are single-cycle; the command outputs are unchanged across an error completion. The scenarios alone can show the rest: the correct field decode, the payload words and their count, the result code for each kind of ending, the exact timeout length, and how many entries are left in the FIFO after a purge or an error.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int ENTRY_W = 36;
  localparam int TAG_W   = 4;
  localparam int DATA_W  = 32;

  localparam logic [TAG_W-1:0] TAG_SOP = 4'h0;
  localparam logic [TAG_W-1:0] TAG_DAT = 4'h1;
  localparam logic [TAG_W-1:0] TAG_EOP = 4'hF;

  typedef enum logic [1:0] {
    RES_OK       = 2'b00,
    RES_UNDERRUN = 2'b01,
    RES_ERROR    = 2'b10
  } res_e;

  typedef struct packed {
    logic [6:0] addr;
    logic [3:0] ep;
    logic [1:0] speed;
    logic [1:0] ep_type;
    logic [1:0] toggle;
    logic [3:0] pid;
  } cmd_t;
endpackage

// File: rtl/txc_cmd_reg.sv
module txc_cmd_reg
  import txc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ENTRY_W-1:0] word_i,
  output cmd_t               cmd_o
);
  cmd_t dec;

  always_comb begin
    dec.addr    = word_i[22:16];
    dec.ep      = word_i[26:23]; // upper endpoint bits unused
    dec.speed   = word_i[9:8];
    dec.ep_type = word_i[7:6];
    dec.toggle  = word_i[5:4];
    dec.pid     = word_i[3:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_o <= '0;
    else if (load_i) cmd_o <= dec;
  end
endmodule

// File: rtl/txc_tmo_timer.sv
module txc_tmo_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/txfifo_cmd_decoder.sv
module txfifo_cmd_decoder
  import txc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fifo_empty_i,
  input  logic [35:0] fifo_data_i,
  output logic        fifo_rd_o,
  input  logic        run_pkt_i,
  output logic        cmd_active_o,
  output logic [6:0]  cmd_addr_o,
  output logic [3:0]  cmd_ep_o,
  output logic [1:0]  cmd_speed_o,
  output logic [1:0]  cmd_type_o,
  output logic [1:0]  cmd_toggle_o,
  output logic [3:0]  cmd_pid_o,
  output logic        data_valid_o,
  output logic [31:0] data_o,
  output logic        bad_pkt_o,
  output logic        done_o,
  output logic [1:0]  done_code_o
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DRAIN, S_TMO, S_PURGE} st_e;

  st_e             st_q, st_d;
  logic            rd, load, dv_d, bad_d, done_d, tmo_exp;
  res_e            code_d;
  logic [TAG_W-1:0] tag;
  logic            have;
  cmd_t            cmd;

  assign tag  = fifo_data_i[ENTRY_W-1 -: TAG_W];
  assign have = !fifo_empty_i;

  always_comb begin
    st_d   = st_q;
    rd     = 1'b0;
    load   = 1'b0;
    dv_d   = 1'b0;
    bad_d  = 1'b0;
    done_d = 1'b0;
    code_d = RES_OK;
    unique case (st_q)
      S_IDLE: if (run_pkt_i) st_d = S_FETCH;
      S_FETCH: if (have) begin
        rd = 1'b1;
        if (tag == TAG_SOP) begin
          load = 1'b1;
          st_d = S_DRAIN;
        end else begin
          done_d = 1'b1;
          code_d = RES_ERROR;
          st_d   = S_IDLE;
        end
      end
      S_DRAIN: begin
        if (!have) begin
          bad_d = 1'b1;
          st_d  = S_TMO;
        end else if (tag == TAG_DAT) begin
          rd   = 1'b1;
          dv_d = 1'b1;
        end else if (tag == TAG_EOP) begin
          rd     = 1'b1;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else begin
          rd     = (tag != TAG_SOP); // next command stays queued
          done_d = 1'b1;
          code_d = RES_ERROR;
          st_d   = S_IDLE;
        end
      end
      S_TMO: if (tmo_exp) st_d = S_PURGE;
      S_PURGE: begin
        if (!have || tag == TAG_SOP) begin
          done_d = 1'b1;
          code_d = RES_UNDERRUN;
          st_d   = S_IDLE;
        end else begin
          rd = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      data_valid_o <= 1'b0;
      data_o       <= '0;
      bad_pkt_o    <= 1'b0;
      done_o       <= 1'b0;
      done_code_o  <= RES_OK;
    end else begin
      st_q         <= st_d;
      data_valid_o <= dv_d;
      bad_pkt_o    <= bad_d;
      done_o       <= done_d;
      if (dv_d)   data_o      <= fifo_data_i[DATA_W-1:0];
      if (done_d) done_code_o <= code_d;
    end
  end

  txc_cmd_reg u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (fifo_data_i),
    .cmd_o  (cmd)
  );

  txc_tmo_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (st_q == S_TMO),
    .expired_o (tmo_exp)
  );

  assign fifo_rd_o    = rd;
  assign cmd_active_o = (st_q == S_DRAIN);
  assign cmd_addr_o   = cmd.addr;
  assign cmd_ep_o     = cmd.ep;
  assign cmd_speed_o  = cmd.speed;
  assign cmd_type_o   = cmd.ep_type;
  assign cmd_toggle_o = cmd.toggle;
  assign cmd_pid_o    = cmd.pid;

  a_r3_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE) |-> !fifo_rd_o);
  a_r11_no_read_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_i |-> !fifo_rd_o);
  a_r7_quiet_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_TMO) |-> !fifo_rd_o);
  a_r7_bad_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_pkt_o |=> !bad_pkt_o);
  a_r8_keep_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PURGE && have && tag == TAG_SOP) |-> !fifo_rd_o);
  a_r9_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_code_o == RES_ERROR && st_q == S_IDLE) |-> $stable(cmd));
endmodule

// File: tb/txfifo_cmd_decoder_test.sv
module txfifo_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;
  localparam logic [1:0] K_OK = 0, K_UR = 1, K_BAD = 2, K_NOEOP = 3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [35:0] cmd;
    logic [3:0]  ndata;
    logic [3:0]  njunk;
    logic        sop_after;
  } vec_t;

  function automatic logic [35:0] mk(input logic [3:0] tg, input logic [6:0] ep7,
      input logic [6:0] ad, input logic [1:0] sp, input logic [1:0] ty,
      input logic [1:0] to, input logic [3:0] pid);
    mk = {tg, 2'b00, ep7, ad, 6'b0, sp, ty, to, pid};
  endfunction

  localparam vec_t VECS [8] = '{
    '{K_OK,    mk(4'h0, 7'h03, 7'h15, 2'd2, 2'd2, 2'd1, 4'h1), 4'd3, 4'd0, 1'b0},
    '{K_OK,    mk(4'h0, 7'h0A, 7'h7F, 2'd0, 2'd3, 2'd2, 4'hD), 4'd0, 4'd0, 1'b0},
    '{K_UR,    mk(4'h0, 7'h05, 7'h22, 2'd1, 2'd1, 2'd0, 4'h1), 4'd2, 4'd3, 1'b1},
    '{K_UR,    mk(4'h0, 7'h0F, 7'h01, 2'd3, 2'd0, 2'd3, 4'h9), 4'd1, 4'd2, 1'b0},
    '{K_BAD,   mk(4'hC, 7'h06, 7'h33, 2'd1, 2'd2, 2'd1, 4'h5), 4'd0, 4'd0, 1'b0},
    '{K_NOEOP, mk(4'h0, 7'h02, 7'h44, 2'd2, 2'd1, 2'd1, 4'hE), 4'd2, 4'd0, 1'b0},
    '{K_UR,    mk(4'h0, 7'h01, 7'h55, 2'd0, 2'd0, 2'd2, 4'h3), 4'd0, 4'd0, 1'b1},
    '{K_OK,    mk(4'h0, 7'h7B, 7'h0C, 2'd1, 2'd3, 2'd0, 4'h7), 4'd5, 4'd0, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0, flush = 1'b0;
  logic [35:0] mem [64];
  logic [5:0]  wp = '0, rp = '0;
  logic        rd, cmd_active, dv, bad, done;
  logic [6:0]  addr;
  logic [3:0]  ep, pid;
  logic [1:0]  spd, typ, tog, code;
  logic [31:0] dat;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (flush)   rp <= wp;
    else if (rd) rp <= rp + 1'b1;
  end

  txfifo_cmd_decoder #(.TIMEOUT_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_empty_i(rp == wp), .fifo_data_i(mem[rp]), .fifo_rd_o(rd),
    .run_pkt_i(run), .cmd_active_o(cmd_active),
    .cmd_addr_o(addr), .cmd_ep_o(ep), .cmd_speed_o(spd), .cmd_type_o(typ),
    .cmd_toggle_o(tog), .cmd_pid_o(pid),
    .data_valid_o(dv), .data_o(dat), .bad_pkt_o(bad),
    .done_o(done), .done_code_o(code)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [35:0] w);
    mem[wp] = w;
    wp = wp + 1'b1;
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [20:0] exp_f;
    exp_f = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state and idle with a loaded FIFO and no request
    push({4'h0, 32'h0});
    push({4'h1, 32'h1234});
    repeat (8) @(negedge clk);
    chk("R9 reset done", {62'd0, done, bad}, 64'd0);
    chk("R3 idle no read", {58'd0, 6'(wp - rp)}, 64'd2);
    chk("R2 reset fields", {43'd0, addr, ep, spd, typ, tog, pid}, 64'd0);
    flush = 1'b1; @(negedge clk); flush = 1'b0;

    for (int vi = 0; vi < 8; vi++) begin
      vec_t v;
      int   n_dv, t_cnt, got_code, dones;
      logic [31:0] sum, exp_sum;
      logic [5:0]  exp_rem;
      logic        t_done, finished;
      v = VECS[vi];
      exp_sum = '0;
      push(v.cmd);
      if (v.kind != K_BAD)
        for (int j = 0; j < v.ndata; j++) begin
          logic [31:0] p;
          p = 32'hA500_0000 + 32'(vi * 256 + j);
          push({4'h1, p});
          exp_sum = exp_sum + p;
        end
      if (v.kind == K_OK)    push({4'hF, 32'h0});
      if (v.kind == K_NOEOP) push({4'h0, 32'h0000_0042});
      run = 1'b1; @(negedge clk); run = 1'b0;
      n_dv = 0; sum = '0; t_cnt = -1; t_done = 1'b0; finished = 1'b0;
      dones = 0; got_code = 0;
      for (int c = 0; c < 400 && !finished; c++) begin
        @(negedge clk);
        if (dv) begin n_dv++; sum = sum + dat; end
        if (bad) begin
          t_cnt = 0;
          for (int j = 0; j < v.njunk; j++) begin
            logic [3:0] tg;
            tg = (j % 3 == 0) ? 4'h1 : (j % 3 == 1) ? 4'hF : 4'h7;
            push({tg, 32'hDEAD_0000 + 32'(j)});
          end
          if (v.sop_after) push({4'h0, 32'h0000_0099});
        end else if (t_cnt >= 0 && !t_done) begin
          t_cnt++;
          if (rd) begin
            t_done = 1'b1;
            if (v.njunk > 0) chk("R7 timeout length", 64'(t_cnt), 64'(TMO));
          end
        end
        if (done) begin
          finished = 1'b1; dones++; got_code = int'(code);
          @(negedge clk);
          if (done) dones++;
        end
      end
      exp_rem = (v.kind == K_NOEOP || (v.kind == K_UR && v.sop_after)) ? 6'd1 : 6'd0;
      if (v.kind != K_BAD)
        exp_f = {v.cmd[22:16], v.cmd[26:23], v.cmd[9:8], v.cmd[7:6], v.cmd[5:4], v.cmd[3:0]};
      case (v.kind)
        K_OK:    chk("R5 ok code", 64'(got_code), 64'd0);
        K_UR:    chk("R8 underrun code", 64'(got_code), 64'd1);
        K_BAD:   chk("R6 error code", 64'(got_code), 64'd2);
        default: chk("R10 missing eop code", 64'(got_code), 64'd2);
      endcase
      chk("R9 one done pulse", 64'(dones), 64'd1);
      chk("R4 data count", 64'(n_dv), (v.kind == K_BAD) ? 64'd0 : 64'(v.ndata));
      chk("R4 data sum", 64'(sum), 64'(exp_sum));
      chk("R2 R6 fields", {43'd0, addr, ep, spd, typ, tog, pid}, {43'd0, exp_f});
      chk("R8 R10 R1 left in fifo", 64'(6'(wp - rp)), 64'(exp_rem));
      if (exp_rem != 0) chk("R1 head is command", 64'(mem[rp][35:32]), 64'd0);
      flush = 1'b1; @(negedge clk); flush = 1'b0;
      @(negedge clk);
    end
    finish_run();
  end
endmodule